// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block is the host's byte-wide window into the packet page memory of a network controller. The memory holds a set of fixed-size pages of 2048 bytes each. The host does not address this memory directly. It loads a 16-bit pointer, one byte at a time, and then reads or writes bytes through a group of four data-register offsets. The block holds the page memory, the pointer register and the address logic.

Two control bits in the pointer set each access. The top bit picks the page. When it is set, the access uses the page at the head of the receive queue. When it is clear, the access uses the current packet number. Both page numbers come from the allocation unit. Bit 14 turns on auto-increment: each data access then steps the 11-bit byte offset by one. When auto-increment is off, the pointer does not move, and the low two bits of the data-register address are added to the offset. This lets the host reach four neighbouring bytes without loading the pointer again.

The frame datapaths share the memory through one dedicated write port. Host reads return one cycle after the request, together with a valid flag.

Top module: `pkt_data_port`

## Requirements
- R1: A write to host offset 6 loads pointer bits 7:0 and a write to offset 7 loads bits 15:8. A read of offset 6 returns bits 7:0 unchanged. A read of offset 7 returns bits 15:8 ANDed with 0xF7, so bit 11 always reads as 0.
- R2: A synchronous active-low reset clears the pointer to 0x0000.
- R3: A data access (host offsets 8 to 11) with pointer bit 15 set goes to the page given by `rx_head_page`. With bit 15 clear, it goes to the page given by `pkt_num`.
- R4: Pointer bits 10:0 give the byte offset within the selected 2048-byte page.
- R5: When pointer bit 14 is set, every data access, read or write, adds one to bits 10:0, wrapping from 0x7FF to 0x000, and leaves bits 15:11 unchanged. A read returns the byte at the offset held before the increment.
- R6: When pointer bit 14 is clear, a data access leaves the pointer unchanged. The byte used is at offset (bits 10:0 + host_addr[1:0]) modulo 2048.
- R7: A host read raises `host_rvalid` on the next cycle, with the data on `host_rdata`. `host_rvalid` is low in every cycle that does not follow a host read.
- R8: The datapath write port stores `dp_wdata` at (`dp_page`, `dp_offs`). If the host and the datapath write the same byte in the same cycle, the datapath value is kept.
- R9: Host writes to offsets other than 6 to 11 change nothing. Host reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| rx_head_page | input | PG_W | Page at the head of the receive queue |
| pkt_num | input | PG_W | Current packet-number page |
| dp_we | input | 1 | Datapath write enable |
| dp_page | input | PG_W | Datapath write page |
| dp_offs | input | OFFS_W | Datapath write byte offset |
| dp_wdata | input | 8 | Datapath write byte |

## Verification
A bad pointer state shows up at once: the very next read of offset 6 or 7 returns the wrong byte. Faults in the offset step or the wrap do not show at the write that causes them. They show at the next data read, which returns a byte from the wrong offset. For that reason the bench checks the pointer value after every run of accesses. A page-select fault shows up only when two pages hold different contents, so the bench fills the two pages with different bytes before it reads across them. A latency fault shows in the very next cycle as a missing or stray valid flag.

// File: rtl/pdp_pkg.sv
// Shared constants for the pointer-addressed packet data port.
// Assumes a byte-wide host bus with a 4-bit register offset.
package pdp_pkg;
    // Host register offsets that the block decodes.
    localparam logic [3:0] OFS_PTR_LO = 4'd6;
    localparam logic [3:0] OFS_PTR_HI = 4'd7;
    // Data window occupies offsets 8..11 (upper two address bits = 2'b10).
    localparam logic [1:0] OFS_DATA_HI = 2'b10;
    // Pointer control bit positions.
    localparam int PTR_QSEL_BIT = 15;
    localparam int PTR_AINC_BIT = 14;
    // Mask applied when reading back the high pointer byte.
    localparam logic [7:0] PTR_HI_RD_MASK = 8'hF7;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_REG  = 2'd1,
        RD_MEM  = 2'd2
    } rd_src_e;

    function automatic logic is_data_ofs(input logic [3:0] a);
        return a[3:2] == OFS_DATA_HI;
    endfunction
endpackage

// File: rtl/pdp_ptr_unit.sv
// Pointer register and access-address generation.
// Holds the 16-bit pointer, loaded one byte at a time. For each data access
// it forms the page and byte offset, and it advances the offset when
// auto-increment is on. Assumes at most one host access per cycle.
module pdp_ptr_unit
    import pdp_pkg::*;
#(
    parameter int PG_W   = 1,
    parameter int OFFS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [7:0]        wdata,
    input  logic              data_acc,
    input  logic [1:0]        win_sel,
    input  logic [PG_W-1:0]   rx_head_page,
    input  logic [PG_W-1:0]   pkt_num,
    output logic [15:0]       ptr,
    output logic [PG_W-1:0]   acc_page,
    output logic [OFFS_W-1:0] acc_offs
);
    logic              ainc;
    logic [OFFS_W-1:0] base_offs;

    assign ainc      = ptr[PTR_AINC_BIT];
    assign base_offs = ptr[OFFS_W-1:0];

    // Pick the page from the queue-select bit.
    always_comb begin
        acc_page = ptr[PTR_QSEL_BIT] ? rx_head_page : pkt_num;
    end

    // Offset: the pointer itself when stepping, else pointer plus window index.
    always_comb begin
        if (ainc) acc_offs = base_offs;
        else      acc_offs = base_offs + OFFS_W'(win_sel);
    end

    // Pointer update: byte loads, or an offset step on auto-increment access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (lo_we) begin
            ptr[7:0] <= wdata;
        end else if (hi_we) begin
            ptr[15:8] <= wdata;
        end else if (data_acc && ainc) begin
            ptr[OFFS_W-1:0] <= base_offs + 1'b1;
        end
    end

    // R5
    ainc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ainc && !lo_we && !hi_we) |=>
        (ptr[OFFS_W-1:0] == $past(ptr[OFFS_W-1:0]) + 1'b1) &&
        (ptr[15:OFFS_W] == $past(ptr[15:OFFS_W])));

    // R6
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ainc && !lo_we && !hi_we) |=> $stable(ptr));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ptr == 16'h0000));
endmodule

// File: rtl/pdp_page_mem.sv
// Packet page memory: PAGES pages of 2**OFFS_W bytes.
// Has two write ports, host and datapath. On a same-address write in the
// same cycle the datapath port wins. One registered read port gives one
// cycle of latency. Contents are not reset.
module pdp_page_mem #(
    parameter int PAGES  = 2,
    parameter int OFFS_W = 11,
    parameter int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              h_we,
    input  logic [PG_W-1:0]   h_page,
    input  logic [OFFS_W-1:0] h_offs,
    input  logic [7:0]        h_wdata,
    input  logic              d_we,
    input  logic [PG_W-1:0]   d_page,
    input  logic [OFFS_W-1:0] d_offs,
    input  logic [7:0]        d_wdata,
    input  logic              rd_en,
    input  logic [PG_W-1:0]   rd_page,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = PAGES << OFFS_W;
    localparam int IDX_W = PG_W + OFFS_W;

    logic [7:0] mem [DEPTH];

    // Writes: host first, datapath last so it overrides on collision.
    always_ff @(posedge clk) begin
        if (h_we) mem[IDX_W'({h_page, h_offs})] <= h_wdata;
        if (d_we) mem[IDX_W'({d_page, d_offs})] <= d_wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[IDX_W'({rd_page, rd_offs})];
    end
endmodule

// File: rtl/pkt_data_port.sv
// Host window into the packet page memory.
// Decodes host offsets 6/7 (pointer bytes) and 8..11 (data window). Routes
// data accesses through the pointer unit to the page memory, and returns
// every read one cycle later with a valid flag. Assumes the allocation unit
// keeps rx_head_page and pkt_num stable around each data access.
module pkt_data_port
    import pdp_pkg::*;
#(
    parameter int PAGES  = 2,
    parameter int OFFS_W = 11,
    localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    input  logic [PG_W-1:0]   rx_head_page,
    input  logic [PG_W-1:0]   pkt_num,
    input  logic              dp_we,
    input  logic [PG_W-1:0]   dp_page,
    input  logic [OFFS_W-1:0] dp_offs,
    input  logic [7:0]        dp_wdata
);
    logic              lo_we, hi_we, data_acc, host_rd;
    logic [15:0]       ptr;
    logic [PG_W-1:0]   acc_page;
    logic [OFFS_W-1:0] acc_offs;
    logic [7:0]        mem_rdata;
    logic [7:0]        reg_rd_d, reg_rd_q;
    rd_src_e           src_d, src_q;

    // Host access decode.
    always_comb begin
        host_rd  = host_sel && !host_wr;
        lo_we    = host_sel && host_wr && (host_addr == OFS_PTR_LO);
        hi_we    = host_sel && host_wr && (host_addr == OFS_PTR_HI);
        data_acc = host_sel && is_data_ofs(host_addr);
    end

    pdp_ptr_unit #(.PG_W(PG_W), .OFFS_W(OFFS_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .lo_we(lo_we), .hi_we(hi_we), .wdata(host_wdata),
        .data_acc(data_acc), .win_sel(host_addr[1:0]),
        .rx_head_page(rx_head_page), .pkt_num(pkt_num),
        .ptr(ptr), .acc_page(acc_page), .acc_offs(acc_offs)
    );

    pdp_page_mem #(.PAGES(PAGES), .OFFS_W(OFFS_W), .PG_W(PG_W)) u_mem (
        .clk(clk),
        .h_we(data_acc && host_wr), .h_page(acc_page), .h_offs(acc_offs),
        .h_wdata(host_wdata),
        .d_we(dp_we), .d_page(dp_page), .d_offs(dp_offs), .d_wdata(dp_wdata),
        .rd_en(data_acc && !host_wr), .rd_page(acc_page), .rd_offs(acc_offs),
        .rd_data(mem_rdata)
    );

    // Select the read source and the register byte for a host read.
    always_comb begin
        reg_rd_d = 8'h00;
        src_d    = RD_NONE;
        if (host_rd) begin
            if (data_acc) begin
                src_d = RD_MEM;
            end else begin
                src_d = RD_REG;
                if (host_addr == OFS_PTR_LO)      reg_rd_d = ptr[7:0];
                else if (host_addr == OFS_PTR_HI) reg_rd_d = ptr[15:8] & PTR_HI_RD_MASK;
            end
        end
    end

    // Read pipeline stage: source tag and register byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= RD_NONE;
            reg_rd_q <= 8'h00;
        end else begin
            src_q    <= src_d;
            reg_rd_q <= reg_rd_d;
        end
    end

    // Output mux for read data and valid.
    always_comb begin
        host_rvalid = (src_q != RD_NONE);
        host_rdata  = (src_q == RD_MEM) ? mem_rdata : reg_rd_q;
    end

    // R7
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr) |=> host_rvalid);

    // R7
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_sel && !host_wr) |=> !host_rvalid);

    // R1
    hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && host_addr == OFS_PTR_HI) |=> (host_rdata[3] == 1'b0));
endmodule

// File: tb/test_pkt_data_port.sv
module test_pkt_data_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [0:0] rx_head_page = 1'b1, pkt_num = 1'b0;
    logic       dp_we = 1'b0;
    logic [0:0] dp_page = '0;
    logic [10:0] dp_offs = '0;
    logic [7:0] dp_wdata = '0;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pkt_data_port #(.PAGES(2), .OFFS_W(11)) i_pkt_data_port (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .rx_head_page(rx_head_page), .pkt_num(pkt_num),
        .dp_we(dp_we), .dp_page(dp_page), .dp_offs(dp_offs), .dp_wdata(dp_wdata)
    );

    // Vector: {wr, addr[3:0], data[7:0], expected[7:0]}; rx_head=1, pkt_num=0.
    localparam int NV = 52;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1,4'h6,8'h00,8'h00}, {1'b1,4'h7,8'h40,8'h00},          // ptr 0x4000
        {1'b1,4'h8,8'h11,8'h00}, {1'b1,4'h9,8'h22,8'h00},          // R5 writes 0,1
        {1'b1,4'hA,8'h33,8'h00},                                   // offs 2
        {1'b0,4'h6,8'h00,8'h03}, {1'b0,4'h7,8'h00,8'h40},          // R5 R1
        {1'b1,4'h6,8'h00,8'h00},
        {1'b0,4'h8,8'h00,8'h11}, {1'b0,4'h8,8'h00,8'h22},          // R5 old offset
        {1'b0,4'h8,8'h00,8'h33}, {1'b0,4'h6,8'h00,8'h03},
        {1'b1,4'h6,8'h00,8'h00}, {1'b1,4'h7,8'h00,8'h00},          // ptr 0x0000
        {1'b0,4'h9,8'h00,8'h22}, {1'b0,4'hA,8'h00,8'h33},          // R6 window add
        {1'b0,4'h8,8'h00,8'h11}, {1'b0,4'h6,8'h00,8'h00},          // R6 unchanged
        {1'b1,4'h7,8'hC0,8'h00}, {1'b1,4'h6,8'h00,8'h00},          // R3 rx page
        {1'b1,4'h8,8'hAA,8'h00}, {1'b1,4'h8,8'hBB,8'h00},
        {1'b1,4'h7,8'h40,8'h00}, {1'b1,4'h6,8'h00,8'h00},
        {1'b0,4'h8,8'h00,8'h11},                                   // R3 pkt page intact
        {1'b1,4'h7,8'h80,8'h00}, {1'b1,4'h6,8'h00,8'h00},
        {1'b0,4'h8,8'h00,8'hAA}, {1'b0,4'h9,8'h00,8'hBB},          // R3
        {1'b1,4'h7,8'hFF,8'h00}, {1'b0,4'h7,8'h00,8'hF7},          // R1 mask
        {1'b0,4'h6,8'h00,8'h00},
        {1'b1,4'h7,8'h47,8'h00}, {1'b1,4'h6,8'hFF,8'h00},          // R4 offs 7FF
        {1'b1,4'h8,8'h5A,8'h00},
        {1'b0,4'h7,8'h00,8'h40}, {1'b0,4'h6,8'h00,8'h00},          // R5 wrap
        {1'b1,4'h7,8'h07,8'h00}, {1'b1,4'h6,8'hFE,8'h00},
        {1'b0,4'h9,8'h00,8'h5A}, {1'b0,4'hB,8'h00,8'h22},          // R6 wrap
        {1'b0,4'h6,8'h00,8'hFE},
        {1'b1,4'h7,8'h50,8'h00}, {1'b1,4'h6,8'h00,8'h00},
        {1'b0,4'h8,8'h00,8'h11}, {1'b0,4'h7,8'h00,8'h50},          // R5 upper kept
        {1'b0,4'h6,8'h00,8'h01},
        {1'b1,4'h0,8'hFF,8'h00}, {1'b0,4'h0,8'h00,8'h00},          // R9
        {1'b0,4'h3,8'h00,8'h00}, {1'b0,4'h6,8'h00,8'h01},          // R9
        {1'b0,4'h7,8'h00,8'h50}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                       output logic v, output logic [7:0] q);
        @(negedge clk);
        host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        v = host_rvalid; q = host_rdata;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        logic v; logic [7:0] q;
        acc(1'b0, a, 8'h00, v, q);
        chk({tag, " R7 valid"}, {7'd0, v}, 8'h01);
        chk(tag, q, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic v; logic [7:0] q;
        acc(1'b1, a, d, v, q);
        chk("R7 no valid after write", {7'd0, v}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        chk("R7 idle valid", {7'd0, host_rvalid}, 8'h00);
        rd(4'h6, 8'h00, "R2 ptr lo after reset");
        rd(4'h7, 8'h00, "R2 ptr hi after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
            else rd(VEC[i][19:16], VEC[i][7:0], $sformatf("vec%0d R1/R3-R6/R9", i));
        end

        // R3: pkt_num change redirects bit15-clear accesses
        pkt_num = 1'b1;
        wr(4'h7, 8'h00); wr(4'h6, 8'h00);
        rd(4'h8, 8'hAA, "R3 pkt_num page 1");
        pkt_num = 1'b0;

        // R8: datapath write then host read
        @(negedge clk);
        dp_we = 1'b1; dp_page = 1'b0; dp_offs = 11'h010; dp_wdata = 8'h77;
        @(negedge clk);
        dp_we = 1'b0;
        wr(4'h6, 8'h10);
        rd(4'h8, 8'h77, "R8 datapath write");
        // R8 collision: datapath wins
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = 4'h8; host_wdata = 8'h99;
        dp_we = 1'b1; dp_page = 1'b0; dp_offs = 11'h010; dp_wdata = 8'h66;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0; dp_we = 1'b0;
        rd(4'h8, 8'h66, "R8 collision");
        wr(4'h8, 8'h99);
        rd(4'h8, 8'h99, "R8 host write alone");

        // R2 mid-run reset
        wr(4'h7, 8'h55); wr(4'h6, 8'hAA);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'h6, 8'h00, "R2 lo after reset");
        rd(4'h7, 8'h00, "R2 hi after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule